// File: doc/BRIEF.md
# Partition Freeze Gate

This block holds the error-isolation state of every partition behind one host bridge and filters the traffic of any partition that is frozen. Each partition number selects an entry with two flags: one guards the memory-mapped I/O path and one guards the DMA path. An error report sets both flags of an entry together. Software can then release the two paths one at a time, through a clear port that carries a separate mask bit for each flag.

Each request carries a partition number, an access kind, a data word and a tag. The block looks up the entry and returns a registered response one cycle later. The response echoes the tag and gives a pass/drop decision. When the request passes, the response carries its data. When a frozen load is answered, the response carries all ones. When a frozen store or interrupt is discarded, the response carries zero.

Each path has its own saturating counter that records how many requests were held back on that path.

Top module: `part_freeze_gate`

## Requirements
- R1: After reset, all 256 entries are unfrozen. Both drop counters read zero, and `rsp_vld_o` is low.
- R2: A freeze report sets both flags of the named entry at the same clock edge. No other entry changes.
- R3: A clear request uses two mask bits: `clr_mmio_i` clears the MMIO flag and `clr_dma_i` clears the DMA flag of the named entry. A flag whose mask bit is low keeps its value.
- R4: A freeze and a clear may name the same entry in the same cycle. In that case the freeze wins, and both flags end up set.
- R5: `rsp_vld_o` and `rsp_tag_o` follow an accepted request by exactly one cycle. The decision uses the entry state held during the request cycle. A freeze or clear at that same edge affects only later requests.
- R6: Kind codes 0 (MMIO load) and 1 (MMIO store) are checked against the MMIO flag only. Codes 2 (DMA read), 3 (DMA write) and 4 (MSI) are checked against the DMA flag only.
- R7: A load to a blocked path (code 0 or 2) responds with `rsp_pass_o`=0 and an all-ones `rsp_data_o`.
- R8: A store or MSI to a blocked path (code 1, 3 or 4) is discarded. It responds with `rsp_pass_o`=0 and a zero `rsp_data_o`.
- R9: A request whose path is not blocked responds with `rsp_pass_o`=1, and `rsp_data_o` equals the request data.
- R10: Every blocked request adds one to the counter of its path: MMIO for codes 0 and 1, DMA for codes 2 to 4. The new count is visible in the same cycle as the response. Each counter holds at its maximum value and never wraps.
- R11: Reserved kind codes 5 to 7 always pass with their data and never count as drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frz_vld_i | input | 1 | Freeze report strobe |
| frz_part_i | input | PART_W | Partition to freeze |
| clr_vld_i | input | 1 | Clear request strobe |
| clr_part_i | input | PART_W | Partition to clear |
| clr_mmio_i | input | 1 | Clear the MMIO flag |
| clr_dma_i | input | 1 | Clear the DMA flag |
| req_vld_i | input | 1 | Request strobe |
| req_part_i | input | PART_W | Request partition |
| req_kind_i | input | 3 | Access kind code |
| req_data_i | input | DATA_W | Request data |
| req_tag_i | input | TAG_W | Request tag |
| rsp_vld_o | output | 1 | Response valid |
| rsp_pass_o | output | 1 | 1 = forwarded, 0 = held back |
| rsp_data_o | output | DATA_W | Forwarded or substituted data |
| rsp_tag_o | output | TAG_W | Echoed request tag |
| drop_mmio_o | output | CNT_W | MMIO-path drop count |
| drop_dma_o | output | CNT_W | DMA-path drop count |

## Verification
The freeze and clear properties compare an entry with its own value one cycle earlier. They therefore expect every port strobe to be either a clean 0 or a clean 1 at each edge, and they allow a freeze and a clear to meet on the same entry. The response properties assume that a request presents a kind code from 0 to 7 and stays stable over the edge on which it is taken. The stimulus drives every input at the falling edge and holds it for a full cycle. It sweeps all 256 partitions through all eight kind codes under several freeze and clear patterns. It then drives one entry past counter saturation on both paths.

// File: rtl/pfz_pkg.sv
package pfz_pkg;
  typedef enum logic [2:0] {
    K_MMIO_LD = 3'd0,
    K_MMIO_ST = 3'd1,
    K_DMA_RD  = 3'd2,
    K_DMA_WR  = 3'd3,
    K_MSI     = 3'd4
  } acc_kind_e;

  function automatic logic kind_is_mmio(input logic [2:0] k);
    return (k == K_MMIO_LD) || (k == K_MMIO_ST);
  endfunction

  function automatic logic kind_is_dma(input logic [2:0] k);
    return (k == K_DMA_RD) || (k == K_DMA_WR) || (k == K_MSI);
  endfunction

  function automatic logic kind_is_load(input logic [2:0] k);
    return (k == K_MMIO_LD) || (k == K_DMA_RD);
  endfunction
endpackage

// File: rtl/pfz_state_table.sv
module pfz_state_table #(
  parameter int PART_W = 8,
  localparam int NUM_PART = 1 << PART_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frz_vld_i,
  input  logic [PART_W-1:0] frz_part_i,
  input  logic              clr_vld_i,
  input  logic [PART_W-1:0] clr_part_i,
  input  logic              clr_mmio_i,
  input  logic              clr_dma_i,
  input  logic [PART_W-1:0] look_part_i,
  output logic              look_mmio_o,
  output logic              look_dma_o
);
  logic [NUM_PART-1:0] mmio_q;
  logic [NUM_PART-1:0] dma_q;

  for (genvar g = 0; g < NUM_PART; g++) begin : g_entry
    logic frz_hit, clr_hit;
    assign frz_hit = frz_vld_i && (frz_part_i == PART_W'(g));
    assign clr_hit = clr_vld_i && (clr_part_i == PART_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mmio_q[g] <= 1'b0;
        dma_q[g]  <= 1'b0;
      end else if (frz_hit) begin
        // freeze has priority over a concurrent clear
        mmio_q[g] <= 1'b1;
        dma_q[g]  <= 1'b1;
      end else if (clr_hit) begin
        if (clr_mmio_i) mmio_q[g] <= 1'b0;
        if (clr_dma_i)  dma_q[g]  <= 1'b0;
      end
    end
  end

  assign look_mmio_o = mmio_q[look_part_i];
  assign look_dma_o  = dma_q[look_part_i];

  assert_freeze_sets_both_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_vld_i |=> mmio_q[$past(frz_part_i)] && dma_q[$past(frz_part_i)]);

  assert_clr_mmio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_vld_i && clr_mmio_i && !(frz_vld_i && frz_part_i == clr_part_i)
    |=> !mmio_q[$past(clr_part_i)]);

  assert_clr_keeps_dma_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_vld_i && !clr_dma_i && !frz_vld_i
    |=> dma_q[$past(clr_part_i)] == $past(dma_q[clr_part_i]));

  assert_freeze_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_vld_i && clr_vld_i && frz_part_i == clr_part_i
    |=> mmio_q[$past(clr_part_i)] && dma_q[$past(clr_part_i)]);
endmodule

// File: rtl/pfz_req_filter.sv
module pfz_req_filter
  import pfz_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_vld_i,
  input  logic [2:0]        req_kind_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic              look_mmio_i,
  input  logic              look_dma_i,
  output logic              blk_mmio_o,
  output logic              blk_dma_o,
  output logic              rsp_vld_o,
  output logic              rsp_pass_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [TAG_W-1:0]  rsp_tag_o
);
  logic k_mmio, k_dma, k_load, blocked;
  logic [DATA_W-1:0] data_nxt;

  assign k_mmio  = kind_is_mmio(req_kind_i);
  assign k_dma   = kind_is_dma(req_kind_i);
  assign k_load  = kind_is_load(req_kind_i);
  assign blocked = (k_mmio && look_mmio_i) || (k_dma && look_dma_i);

  always_comb begin
    if (!blocked)    data_nxt = req_data_i;
    else if (k_load) data_nxt = '1;
    else             data_nxt = '0;
  end

  assign blk_mmio_o = req_vld_i && k_mmio && look_mmio_i;
  assign blk_dma_o  = req_vld_i && k_dma && look_dma_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_o  <= 1'b0;
      rsp_pass_o <= 1'b0;
      rsp_data_o <= '0;
      rsp_tag_o  <= '0;
    end else begin
      rsp_vld_o <= req_vld_i;
      if (req_vld_i) begin
        rsp_pass_o <= !blocked;
        rsp_data_o <= data_nxt;
        rsp_tag_o  <= req_tag_i;
      end
    end
  end

  assert_rsp_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |=> rsp_vld_o && rsp_tag_o == $past(req_tag_i));

  assert_frozen_load_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i && ((req_kind_i == K_MMIO_LD && look_mmio_i) || (req_kind_i == K_DMA_RD && look_dma_i))
    |=> !rsp_pass_o && (&rsp_data_o));

  assert_frozen_store_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i && ((req_kind_i == K_MMIO_ST && look_mmio_i) ||
                  ((req_kind_i == K_DMA_WR || req_kind_i == K_MSI) && look_dma_i))
    |=> !rsp_pass_o && rsp_data_o == '0);

  assert_open_passes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i && !look_mmio_i && !look_dma_i |=> rsp_pass_o && rsp_data_o == $past(req_data_i));

  assert_reserved_passes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i && req_kind_i > 3'd4 |=> rsp_pass_o && !$past(blk_mmio_o) && !$past(blk_dma_o));
endmodule

// File: rtl/pfz_sat_cnt.sv
module pfz_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (inc_i && !(&cnt_o)) cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_holds_max_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o) |=> (&cnt_o));

  assert_cnt_steps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !(&cnt_o) |=> cnt_o == $past(cnt_o) + 1'b1);

  assert_cnt_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/part_freeze_gate.sv
module part_freeze_gate #(
  parameter int PART_W = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frz_vld_i,
  input  logic [PART_W-1:0] frz_part_i,
  input  logic              clr_vld_i,
  input  logic [PART_W-1:0] clr_part_i,
  input  logic              clr_mmio_i,
  input  logic              clr_dma_i,
  input  logic              req_vld_i,
  input  logic [PART_W-1:0] req_part_i,
  input  logic [2:0]        req_kind_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic              rsp_vld_o,
  output logic              rsp_pass_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [CNT_W-1:0]  drop_mmio_o,
  output logic [CNT_W-1:0]  drop_dma_o
);
  localparam int NUM_PATH = 2;

  logic look_mmio, look_dma;
  logic [NUM_PATH-1:0] blk;
  logic [CNT_W-1:0] cnt [NUM_PATH];

  pfz_state_table #(.PART_W(PART_W)) u_table (
    .clk_i, .rst_ni,
    .frz_vld_i, .frz_part_i,
    .clr_vld_i, .clr_part_i, .clr_mmio_i, .clr_dma_i,
    .look_part_i (req_part_i),
    .look_mmio_o (look_mmio),
    .look_dma_o  (look_dma)
  );

  pfz_req_filter #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_filter (
    .clk_i, .rst_ni,
    .req_vld_i, .req_kind_i, .req_data_i, .req_tag_i,
    .look_mmio_i (look_mmio),
    .look_dma_i  (look_dma),
    .blk_mmio_o  (blk[0]),
    .blk_dma_o   (blk[1]),
    .rsp_vld_o, .rsp_pass_o, .rsp_data_o, .rsp_tag_o
  );

  for (genvar g = 0; g < NUM_PATH; g++) begin : g_cnt
    pfz_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .inc_i (blk[g]),
      .cnt_o (cnt[g])
    );
  end

  assign drop_mmio_o = cnt[0];
  assign drop_dma_o  = cnt[1];
endmodule

// File: tb/part_freeze_gate_tb.sv
`timescale 1ns/1ps
module part_freeze_gate_tb;
  localparam int PART_W = 8;
  localparam int NP     = 1 << PART_W;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;
  localparam int CNT_W  = 8;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frz_vld = 0, clr_vld = 0, clr_m = 0, clr_d = 0, req_vld = 0;
  logic [PART_W-1:0] frz_part = 0, clr_part = 0, req_part = 0;
  logic [2:0] req_kind = 0;
  logic [DATA_W-1:0] req_data = 0;
  logic [TAG_W-1:0] req_tag = 0;
  logic rsp_vld, rsp_pass;
  logic [DATA_W-1:0] rsp_data;
  logic [TAG_W-1:0] rsp_tag;
  logic [CNT_W-1:0] drop_mmio, drop_dma;

  always #2 clk = ~clk;

  part_freeze_gate #(.PART_W(PART_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .frz_vld_i(frz_vld), .frz_part_i(frz_part),
    .clr_vld_i(clr_vld), .clr_part_i(clr_part), .clr_mmio_i(clr_m), .clr_dma_i(clr_d),
    .req_vld_i(req_vld), .req_part_i(req_part), .req_kind_i(req_kind),
    .req_data_i(req_data), .req_tag_i(req_tag),
    .rsp_vld_o(rsp_vld), .rsp_pass_o(rsp_pass), .rsp_data_o(rsp_data), .rsp_tag_o(rsp_tag),
    .drop_mmio_o(drop_mmio), .drop_dma_o(drop_dma)
  );

  int vecs = 0, errs = 0;
  bit m_mmio [NP];
  bit m_dma  [NP];
  int c_mmio = 0, c_dma = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  function automatic logic [DATA_W-1:0] pat(input int p, input int k, input int s);
    return DATA_W'(32'h5A3C_0000 ^ (p * 32'd40503) ^ (k << 24) ^ (s * 32'd977));
  endfunction

  // drive one cycle of freeze/clear activity, update model afterwards
  task automatic ctl(input bit fv, input int fp, input bit cv, input int cp,
                     input bit cm, input bit cd);
    frz_vld = fv; frz_part = PART_W'(fp);
    clr_vld = cv; clr_part = PART_W'(cp); clr_m = cm; clr_d = cd;
    @(negedge clk);
    frz_vld = 0; clr_vld = 0;
    if (cv && !(fv && fp == cp)) begin
      if (cm) m_mmio[cp] = 0;
      if (cd) m_dma[cp]  = 0;
    end
    if (fv) begin m_mmio[fp] = 1; m_dma[fp] = 1; end
  endtask

  // request with optional concurrent freeze of fp (R5 ordering)
  task automatic req(input int p, input int k, input int s, input bit fv, input int fp);
    logic [DATA_W-1:0] d, ed;
    bit mm, dm, ld, blk;
    logic [TAG_W-1:0] t;
    string rq;
    d = pat(p, k, s);
    t = TAG_W'(p + k + s);
    mm = (k == 0 || k == 1);
    dm = (k >= 2 && k <= 4);
    ld = (k == 0 || k == 2);
    blk = (mm && m_mmio[p]) || (dm && m_dma[p]);
    ed = !blk ? d : (ld ? '1 : '0);
    if (k > 4) rq = "R11";
    else if (!blk) rq = "R9";
    else if (ld) rq = "R7";
    else rq = "R8";
    req_vld = 1; req_part = PART_W'(p); req_kind = 3'(k); req_data = d; req_tag = t;
    frz_vld = fv; frz_part = PART_W'(fp);
    @(negedge clk);
    req_vld = 0; frz_vld = 0;
    if (fv) begin m_mmio[fp] = 1; m_dma[fp] = 1; end
    if (blk && mm && c_mmio < CMAX) c_mmio++;
    if (blk && dm && c_dma < CMAX) c_dma++;
    chk("R5 vld", 64'(rsp_vld), 64'd1);
    chk("R5 tag", 64'(rsp_tag), 64'(t));
    chk({rq, " R6 pass"}, 64'(rsp_pass), 64'(!blk));
    chk({rq, " data"}, 64'(rsp_data), 64'(ed));
    chk("R10 mmio cnt", 64'(drop_mmio), 64'(c_mmio));
    chk("R10 dma cnt", 64'(drop_dma), 64'(c_dma));
  endtask

  task automatic sweep(input int s);
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < 8; k++)
        req(p, k, s, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_mmio[p] = 0; m_dma[p] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 vld", 64'(rsp_vld), 64'd0);
    chk("R1 mmio cnt", 64'(drop_mmio), 64'd0);
    chk("R1 dma cnt", 64'(drop_dma), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 vld idle", 64'(rsp_vld), 64'd0);
    sweep(1); // R1: all unfrozen

    for (int p = 0; p < NP; p += 3) ctl(1, p, 0, 0, 0, 0); // R2
    sweep(2);

    for (int p = 0; p < NP; p += 6) ctl(0, 0, 1, p, 1, 0);  // R3 mmio only
    for (int p = 3; p < NP; p += 6) ctl(0, 0, 1, p, 0, 1);  // R3 dma only
    ctl(0, 0, 1, 7, 1, 1);                                   // clear of an open entry
    sweep(3);

    ctl(1, 12, 1, 12, 1, 1);  // R4 same entry
    ctl(1, 40, 1, 42, 1, 1);  // different entries
    ctl(1, 255, 1, 0, 1, 1);
    sweep(4);

    // R5: concurrent freeze does not affect the request in the same cycle
    req(100, 0, 5, 1, 100);
    req(100, 0, 5, 0, 0);
    req(101, 3, 5, 1, 101);
    req(101, 4, 5, 0, 0);

    // R10 saturation on both paths
    ctl(1, 200, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) req(200, 1, i, 0, 0);
    for (int i = 0; i < 300; i++) req(200, 3, i, 0, 0);
    chk("R10 mmio sat", 64'(drop_mmio), 64'(CMAX));
    chk("R10 dma sat", 64'(drop_dma), 64'(CMAX));

    // R3 release paths one at a time on 200
    ctl(0, 0, 1, 200, 1, 0);
    req(200, 0, 9, 0, 0);
    req(200, 2, 9, 0, 0);
    ctl(0, 0, 1, 200, 0, 1);
    req(200, 4, 9, 0, 0);
    summary();
  end
endmodule